// File: doc/BRIEF.md
# RTC Shadow Register Commit Front End

This block sits between a 16-bit host register bus and the always-on domain of a battery-backed real-time clock. Host writes do not go straight to the always-on settings. They land in shadow registers. An explicit commit then copies them across as one set, and a busy flag shows when that copy has finished.

Most settings are guarded. The configuration and power-key registers take writes only after a two-word unlock has been completed through two commits. The power-control register accepts a write only when its upper byte holds a key byte. The oscillator register has its own three-write unlock sequence. A reload request copies the committed state back into the shadows. The interrupt status register is cleared by reading it. A valid-configuration output is raised when both committed power keys hold their magic patterns and the supply has not been lost.

Word addresses: power control 0x0000, interrupt status 0x0001, configuration 0x0002, power key one 0x0003, power key two 0x0004, oscillator 0x0005, protection 0x0006, commit trigger 0x0007. A read returns its data on `rdData` in the cycle after `rdEn`.

Top module: `rtc_commit_front`

## Requirements
- R1: Writes to configuration (0x0002) and the power keys (0x0003, 0x0004) are dropped while locked. The lock opens after 0x586A is written to protection (0x0006) and committed, and then 0x9136 is written and committed. A protection read returns 0x0001 when open and 0x0000 otherwise.
- R2: Any write to protection other than the expected next word returns the lock to locked at once. A later commit does not open it.
- R3: Writing a value with bit 0 set to the trigger (0x0007) while idle raises `busy` and bit 6 of a power-control read. `busy` stays high for exactly BUSY_TICKS `slowTick` pulses. Committed outputs change only when `busy` falls.
- R4: A trigger write while `busy` is high neither restarts nor extends the busy period.
- R5: A power-control write takes effect only when data[15:8] is 0x43. Bit 0 (enable), bit 2 (power on), bit 3 (auto) and bit 4 (clear keys) are stored in the shadow. A read returns them in bits 4:0. After a commit they drive `pwrEnable`, `pwrOnOut` and `autoPower`.
- R6: `cfgValid` is high only when the committed key one is 0xA357, the committed key two is 0x67D2, and `supplyLost` is low.
- R7: Bit 15 of a configuration read mirrors `supplyLost`, and `supplyLost` high forces `cfgValid` low.
- R8: The oscillator shadow (0x0005) accepts a value only on the write that follows 0x1A57 and then 0x2B68. Any other word breaks the sequence.
- R9: Interrupt status bits are set by `irqEvent`. A read of 0x0001 returns the bits and clears them. An event arriving in the read cycle is kept for the next read.
- R10: A keyed power-control write with bit 5 set copies every committed value back into its shadow register.
- R11: A commit with the clear-keys bit (bit 4) set in the power-control shadow zeroes both committed power keys.
- R12: After reset, all shadow and committed values are zero, the lock is closed, `busy` is low and `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle pulse per slow-clock period |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 16 | Word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid the cycle after rdEn |
| irqEvent | input | 4 | Interrupt event pulses from the calendar |
| supplyLost | input | 1 | Raw lost-supply status |
| busy | output | 1 | Commit in progress |
| pwrEnable | output | 1 | Committed enable bit |
| pwrOnOut | output | 1 | Committed power-on output |
| autoPower | output | 1 | Committed auto bit |
| cfgValid | output | 1 | Power keys match and supply intact |
| oscSetting | output | 16 | Committed oscillator value |
| ctrlSetting | output | 15 | Committed configuration bits |

## Verification
A lock state that is stuck or wrongly advanced shows up on the first read of the protection or key registers after the two commits. A wrong busy counter moves the falling edge of `busy` and the update of the committed outputs by one or more `slowTick` pulses, and this is seen at the exact pulse where it happens. A broken oscillator sequence or reload path shows up on the next oscillator or power-control read. A missed read-clear shows up as a non-zero second status read.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;
  localparam logic [15:0] ADR_PWR  = 16'h0000;
  localparam logic [15:0] ADR_IRQ  = 16'h0001;
  localparam logic [15:0] ADR_CTRL = 16'h0002;
  localparam logic [15:0] ADR_KEY1 = 16'h0003;
  localparam logic [15:0] ADR_KEY2 = 16'h0004;
  localparam logic [15:0] ADR_OSC  = 16'h0005;
  localparam logic [15:0] ADR_PROT = 16'h0006;
  localparam logic [15:0] ADR_TRIG = 16'h0007;

  localparam logic [7:0]  PWR_KEY  = 8'h43;
  localparam logic [15:0] PROT_W1  = 16'h586A;
  localparam logic [15:0] PROT_W2  = 16'h9136;
  localparam logic [15:0] OSC_W1   = 16'h1A57;
  localparam logic [15:0] OSC_W2   = 16'h2B68;
  localparam logic [15:0] VALID_K1 = 16'hA357;
  localparam logic [15:0] VALID_K2 = 16'h67D2;

  typedef enum logic [2:0] {LK_SHUT, LK_ARM1, LK_HALF, LK_ARM2, LK_OPEN} lockT;
  typedef enum logic [1:0] {OS_IDLE, OS_ONE, OS_TWO} oscT;

  // strobes from control to datapath
  typedef struct packed {
    logic wrPwr;
    logic wrCtrl;
    logic wrKey1;
    logic wrKey2;
    logic wrOsc;
    logic reload;
    logic commitDone;
    logic irqRd;
  } stbT;
endpackage

// File: rtl/rtcfe_ctrl.sv
module rtcfe_ctrl
  import rtcfe_pkg::*;
#(
  parameter int BUSY_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slowTick,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [15:0] addr,
  input  logic [15:0] wrData,
  output stbT         stb,
  output logic        busy,
  output logic        lockOpen
);
  localparam int CW = $clog2(BUSY_TICKS + 1);

  logic [CW-1:0] cnt;
  lockT lockQ;
  oscT  oscQ;
  logic trigHit, doneNow, keyOk, protWr, oscWr;

  always_comb begin
    trigHit = wrEn && (addr == ADR_TRIG) && wrData[0];
    doneNow = busy && slowTick && (cnt == CW'(1));
    keyOk   = (wrData[15:8] == PWR_KEY);
    protWr  = wrEn && (addr == ADR_PROT);
    oscWr   = wrEn && (addr == ADR_OSC);
    stb.wrPwr      = wrEn && (addr == ADR_PWR) && keyOk && !wrData[5];
    stb.reload     = wrEn && (addr == ADR_PWR) && keyOk && wrData[5];
    stb.wrCtrl     = wrEn && (addr == ADR_CTRL) && (lockQ == LK_OPEN);
    stb.wrKey1     = wrEn && (addr == ADR_KEY1) && (lockQ == LK_OPEN);
    stb.wrKey2     = wrEn && (addr == ADR_KEY2) && (lockQ == LK_OPEN);
    stb.wrOsc      = oscWr && (oscQ == OS_TWO);
    stb.commitDone = doneNow;
    stb.irqRd      = rdEn && (addr == ADR_IRQ);
    lockOpen       = (lockQ == LK_OPEN);
  end

  // busy window counted in slow ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy && trigHit) begin
      busy <= 1'b1;
      cnt  <= CW'(BUSY_TICKS);
    end else if (busy && slowTick) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  // write-protection sequence, each word confirmed by a commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= LK_SHUT;
    end else if (protWr) begin
      if (lockQ == LK_HALF && wrData == PROT_W2) lockQ <= LK_ARM2;
      else if (wrData == PROT_W1)                lockQ <= LK_ARM1;
      else                                       lockQ <= LK_SHUT;
    end else if (doneNow) begin
      if (lockQ == LK_ARM1)      lockQ <= LK_HALF;
      else if (lockQ == LK_ARM2) lockQ <= LK_OPEN;
    end
  end

  // oscillator unlock sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscQ <= OS_IDLE;
    end else if (oscWr) begin
      unique case (oscQ)
        OS_IDLE: oscQ <= (wrData == OSC_W1) ? OS_ONE : OS_IDLE;
        OS_ONE: begin
          if (wrData == OSC_W2)      oscQ <= OS_TWO;
          else if (wrData == OSC_W1) oscQ <= OS_ONE;
          else                       oscQ <= OS_IDLE;
        end
        default: oscQ <= OS_IDLE;
      endcase
    end
  end

  assert_busy_from_trigger_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigHit));

  assert_retrigger_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && trigHit && !slowTick) |=> (busy && cnt == $past(cnt)));

  assert_open_needs_commit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOpen) |-> $past(doneNow));

  assert_bad_word_locks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (protWr && wrData != PROT_W1 && wrData != PROT_W2) |=> !lockOpen);
endmodule

// File: rtl/rtcfe_dpath.sv
module rtcfe_dpath
  import rtcfe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  stbT         stb,
  input  logic        busy,
  input  logic        lockOpen,
  input  logic        rdEn,
  input  logic [15:0] addr,
  input  logic [15:0] wrData,
  input  logic [3:0]  irqEvent,
  input  logic        supplyLost,
  output logic [15:0] rdData,
  output logic        pwrEnable,
  output logic        pwrOnOut,
  output logic        autoPower,
  output logic        cfgValid,
  output logic [15:0] oscSetting,
  output logic [14:0] ctrlSetting
);
  logic [4:0]  shPwr, comPwr;
  logic [14:0] shCtrl, comCtrl;
  logic [15:0] shKey1, shKey2, comKey1, comKey2, shOsc, comOsc;
  logic [3:0]  irqQ;
  logic [15:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPwr  <= '0;
      shCtrl <= '0;
      shKey1 <= '0;
      shKey2 <= '0;
      shOsc  <= '0;
    end else if (stb.reload) begin
      shPwr  <= comPwr;
      shCtrl <= comCtrl;
      shKey1 <= comKey1;
      shKey2 <= comKey2;
      shOsc  <= comOsc;
    end else begin
      if (stb.wrPwr)  shPwr  <= wrData[4:0];
      if (stb.wrCtrl) shCtrl <= wrData[14:0];
      if (stb.wrKey1) shKey1 <= wrData;
      if (stb.wrKey2) shKey2 <= wrData;
      if (stb.wrOsc)  shOsc  <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comPwr  <= '0;
      comCtrl <= '0;
      comKey1 <= '0;
      comKey2 <= '0;
      comOsc  <= '0;
    end else if (stb.commitDone) begin
      comPwr  <= shPwr;
      comCtrl <= shCtrl;
      comOsc  <= shOsc;
      comKey1 <= shPwr[4] ? 16'h0000 : shKey1;
      comKey2 <= shPwr[4] ? 16'h0000 : shKey2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= '0;
    else       irqQ <= (stb.irqRd ? 4'h0 : irqQ) | irqEvent;
  end

  always_comb begin
    unique case (addr)
      ADR_PWR:  rdMux = {9'b0, busy, 1'b0, shPwr};
      ADR_IRQ:  rdMux = {12'b0, irqQ};
      ADR_CTRL: rdMux = {supplyLost, shCtrl};
      ADR_KEY1: rdMux = shKey1;
      ADR_KEY2: rdMux = shKey2;
      ADR_OSC:  rdMux = shOsc;
      ADR_PROT: rdMux = {15'b0, lockOpen};
      default:  rdMux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  always_comb begin
    pwrEnable   = comPwr[0];
    pwrOnOut    = comPwr[2];
    autoPower   = comPwr[3];
    oscSetting  = comOsc;
    ctrlSetting = comCtrl;
    cfgValid    = (comKey1 == VALID_K1) && (comKey2 == VALID_K2) && !supplyLost;
  end

  assert_irq_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.irqRd && irqEvent == 4'h0) |=> (irqQ == 4'h0));

  assert_osc_only_unlocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shOsc) |-> $past(stb.wrOsc || stb.reload));

  assert_keys_move_on_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(comKey1) |-> $past(stb.commitDone));
endmodule

// File: rtl/rtc_commit_front.sv
module rtc_commit_front
  import rtcfe_pkg::*;
#(
  parameter int BUSY_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        slowTick,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [15:0] addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic [3:0]  irqEvent,
  input  logic        supplyLost,
  output logic        busy,
  output logic        pwrEnable,
  output logic        pwrOnOut,
  output logic        autoPower,
  output logic        cfgValid,
  output logic [15:0] oscSetting,
  output logic [14:0] ctrlSetting
);
  stbT  stb;
  logic lockOpen;

  rtcfe_ctrl #(.BUSY_TICKS(BUSY_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .stb(stb), .busy(busy), .lockOpen(lockOpen)
  );

  rtcfe_dpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .lockOpen(lockOpen),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .irqEvent(irqEvent),
    .supplyLost(supplyLost), .rdData(rdData), .pwrEnable(pwrEnable),
    .pwrOnOut(pwrOnOut), .autoPower(autoPower), .cfgValid(cfgValid),
    .oscSetting(oscSetting), .ctrlSetting(ctrlSetting)
  );
endmodule

// File: tb/sim_rtc_commit_front.sv
`timescale 1ns/1ps
module sim_rtc_commit_front;
  localparam int BT = 4;
  localparam int NV = 18;
  // {op(2): 0 write, 1 read-check, 2 commit ; addr ; data ; expected}
  localparam logic [49:0] VEC [NV] = '{
    {2'd1, 16'h0002, 16'h0000, 16'h0000},
    {2'd0, 16'h0003, 16'hA357, 16'h0000},
    {2'd1, 16'h0003, 16'h0000, 16'h0000},
    {2'd0, 16'h0006, 16'h586A, 16'h0000},
    {2'd2, 16'h0007, 16'h0001, 16'h0000},
    {2'd0, 16'h0006, 16'h9136, 16'h0000},
    {2'd2, 16'h0007, 16'h0001, 16'h0000},
    {2'd1, 16'h0006, 16'h0000, 16'h0001},
    {2'd0, 16'h0003, 16'hA357, 16'h0000},
    {2'd0, 16'h0004, 16'h67D2, 16'h0000},
    {2'd1, 16'h0004, 16'h0000, 16'h67D2},
    {2'd0, 16'h0002, 16'h1234, 16'h0000},
    {2'd1, 16'h0002, 16'h0000, 16'h1234},
    {2'd0, 16'h0000, 16'h430D, 16'h0000},
    {2'd1, 16'h0000, 16'h0000, 16'h000D},
    {2'd0, 16'h0000, 16'h1201, 16'h0000},
    {2'd1, 16'h0000, 16'h0000, 16'h000D},
    {2'd2, 16'h0007, 16'h0001, 16'h0000}
  };

  logic clk = 1'b0, rstN = 1'b0, slowTick = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic supplyLost = 1'b0;
  logic [15:0] addr = '0, wrData = '0;
  logic [3:0] irqEvent = '0;
  logic [15:0] rdData, oscSetting;
  logic [14:0] ctrlSetting;
  logic busy, pwrEnable, pwrOnOut, autoPower, cfgValid;
  int nChk = 0, nFail = 0;
  logic finished = 1'b0;
  logic [15:0] got;

  always #2 clk = ~clk;

  rtc_commit_front #(.BUSY_TICKS(BT)) u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqEvent(irqEvent),
    .supplyLost(supplyLost), .busy(busy), .pwrEnable(pwrEnable),
    .pwrOnOut(pwrOnOut), .autoPower(autoPower), .cfgValid(cfgValid),
    .oscSetting(oscSetting), .ctrlSetting(ctrlSetting)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; v = rdData;
  endtask

  task automatic tick();
    @(negedge clk); slowTick = 1'b1;
    @(negedge clk); slowTick = 1'b0;
  endtask

  task automatic commit();
    wr(16'h0007, 16'h0001);
    repeat (BT) tick();
  endtask

  task automatic oscSeq(input logic [15:0] v);
    wr(16'h0005, 16'h1A57);
    wr(16'h0005, 16'h2B68);
    wr(16'h0005, v);
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0: return "R12 reset read";
      2: return "R1 locked key write dropped";
      7: return "R1 lock open";
      10, 12: return "R1 protected write after unlock";
      default: return "R5 keyed power write";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 busy after reset", {15'b0, busy}, 16'h0);
    chk("R12 cfgValid after reset", {15'b0, cfgValid}, 16'h0);
    chk("R12 rdData after reset", rdData, 16'h0);
    chk("R12 osc after reset", oscSetting, 16'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][49:48])
        2'd0: wr(VEC[i][47:32], VEC[i][31:16]);
        2'd1: begin
          rd(VEC[i][47:32], got);
          chk(tagOf(i), got, VEC[i][15:0]);
        end
        default: commit();
      endcase
    end

    chk("R5 pwrEnable", {15'b0, pwrEnable}, 16'h1);
    chk("R5 pwrOnOut", {15'b0, pwrOnOut}, 16'h1);
    chk("R5 autoPower", {15'b0, autoPower}, 16'h1);
    chk("R6 cfgValid keys match", {15'b0, cfgValid}, 16'h1);
    chk("R1 ctrlSetting committed", {1'b0, ctrlSetting}, 16'h1234);

    // R7 lost supply
    @(negedge clk); supplyLost = 1'b1;
    @(negedge clk);
    chk("R7 cfgValid with supply lost", {15'b0, cfgValid}, 16'h0);
    rd(16'h0002, got);
    chk("R7 config bit15", got, 16'h9234);
    supplyLost = 1'b0;

    // R2 broken sequence
    wr(16'h0006, 16'h1111);
    rd(16'h0006, got);
    chk("R2 relock on bad word", got, 16'h0000);
    wr(16'h0003, 16'h0000);
    rd(16'h0003, got);
    chk("R2 key write dropped after relock", got, 16'hA357);
    wr(16'h0006, 16'h586A);
    wr(16'h0006, 16'h0000);
    commit();
    wr(16'h0006, 16'h9136);
    commit();
    rd(16'h0006, got);
    chk("R2 broken sequence stays locked", got, 16'h0000);

    // R8 and R3: oscillator unlock, busy length
    oscSeq(16'h0003);
    rd(16'h0005, got);
    chk("R8 osc accepted after sequence", got, 16'h0003);
    wr(16'h0007, 16'h0001);
    rd(16'h0000, got);
    chk("R3 busy bit in power read", got & 16'h0040, 16'h0040);
    repeat (BT - 1) tick();
    chk("R3 busy before last tick", {15'b0, busy}, 16'h1);
    chk("R3 osc not yet committed", oscSetting, 16'h0000);
    tick();
    chk("R3 busy after last tick", {15'b0, busy}, 16'h0);
    chk("R3 osc committed", oscSetting, 16'h0003);

    // R4 retrigger during busy
    oscSeq(16'h0005);
    wr(16'h0007, 16'h0001);
    repeat (2) tick();
    wr(16'h0007, 16'h0001);
    repeat (BT - 2) tick();
    chk("R4 busy not extended", {15'b0, busy}, 16'h0);
    chk("R4 commit on original schedule", oscSetting, 16'h0005);

    // R8 negative cases
    wr(16'h0005, 16'h0007);
    rd(16'h0005, got);
    chk("R8 direct osc write dropped", got, 16'h0005);
    wr(16'h0005, 16'h1A57);
    wr(16'h0005, 16'h5555);
    wr(16'h0005, 16'h2B68);
    wr(16'h0005, 16'h0007);
    rd(16'h0005, got);
    chk("R8 broken osc sequence", got, 16'h0005);

    // R10 reload
    oscSeq(16'h0009);
    rd(16'h0005, got);
    chk("R10 shadow changed before reload", got, 16'h0009);
    wr(16'h0000, 16'h432D);
    rd(16'h0005, got);
    chk("R10 osc reloaded", got, 16'h0005);
    rd(16'h0000, got);
    chk("R10 power reloaded", got, 16'h000D);

    // R9 interrupt status
    @(negedge clk); irqEvent = 4'h5;
    @(negedge clk); irqEvent = 4'h0;
    rd(16'h0001, got);
    chk("R9 status read", got, 16'h0005);
    @(negedge clk); rdEn = 1'b1; addr = 16'h0001; irqEvent = 4'h2;
    @(negedge clk); rdEn = 1'b0; irqEvent = 4'h0; got = rdData;
    chk("R9 status cleared by read", got, 16'h0000);
    rd(16'h0001, got);
    chk("R9 event in read cycle kept", got, 16'h0002);

    // R11 clear keys
    wr(16'h0000, 16'h431D);
    commit();
    chk("R11 keys cleared by commit", {15'b0, cfgValid}, 16'h0);
    chk("R11 enable kept", {15'b0, pwrEnable}, 16'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule